// File: doc/BRIEF.md
# Circuit Breaker Retry Controller

This block sits between an overcurrent timer and the enable pins of a set of protected outputs. By default there are two: channel 0 drives a power output and channel 1 drives a line driver. Each channel turns its output on while the host requests it. When the channel's breaker trips, the controller drops the output at once and raises a sticky overcurrent event bit for the host.

Recovery is chosen per channel by a mode bit. In auto-retry mode the output stays off for a cooling delay and is then switched back on. If the fault is still there, the breaker trips again and the off/wait cycle repeats. In latchoff mode the output stays off until the host clears the channel's event bit, and that clear is itself the retry. The cooling delay comes from a shared 3-bit code. It counts ticks of a shared prescaler, so a short tick period can scale the delay down for simulation.

Top module: `brk_retry_ctrl`

## Requirements
- R1: After reset every output enable and event bit is 0, every channel's mode bit is 1 (auto-retry) and the delay code is 0.
- R2: In the cycle after `en_req_i[i]` is sampled high, `out_en_o[i]` goes high if the channel is idle. Sampling `en_req_i[i]` low drives `out_en_o[i]` low in the next cycle from any state, and the channel then stays off regardless of trips or timing.
- R3: A trip sampled while a channel's output is on drives that output low and sets `evt_o[i]` in the next cycle.
- R4: In auto-retry mode (mode bit 1) with code c, the output comes back after BASE_TICKS·2^c prescaler ticks. With tick period D that is between (BASE_TICKS·2^c−1)·D+1 and BASE_TICKS·2^c·D cycles of output low.
- R5: Each step of the 3-bit delay code doubles the cooling delay (checked at codes 0, 2 and 7).
- R6: In latchoff mode (mode bit 0) a tripped output stays off for as long as its event bit is not cleared. A clear pulse on `evt_clr_i[i]` turns the output back on and clears the event in the next cycle.
- R7: Mode bits act per channel. One channel may be latched off while another retries automatically.
- R8: The event bit is sticky in auto-retry mode and stays set after the output returns. Clearing it during the cooling wait does not change the retry time.
- R9: A trip in the same cycle as a clear counts as a new fault. The event bit stays set, and the output stays or goes off.
- R10: If the output trips again after an automatic retry, the full cooling delay repeats.
- R11: A trip on a channel whose output is off and not latched is ignored and leaves its event bit unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en_req_i | input | NUM_CH | Per-channel enable request from the host |
| trip_i | input | NUM_CH | Per-channel breaker trip from the overcurrent timer |
| evt_clr_i | input | NUM_CH | Per-channel clear strobe for the event bit |
| cfg_we_i | input | 1 | Write strobe for the configuration register |
| cfg_auto_i | input | NUM_CH | Mode bits to write: 1 auto-retry, 0 latchoff |
| cfg_code_i | input | 3 | Cooling delay code to write |
| out_en_o | output | NUM_CH | Per-channel output enable |
| evt_o | output | NUM_CH | Per-channel sticky overcurrent event bit |

## Verification
The bench measures the off-time of every automatic retry against its allowed window. An off-by-one in the countdown, or a shift that does not double per code step, makes the measured time fall outside that window. It clears the event mid-wait to catch a design that restarts or cancels the wait on a clear. It also pulses trip and clear in the same cycle, both on a running output and on a latched one; a design that lets the clear win would lose a fault or turn a faulted output back on. Finally, it trips idle channels and drops the enable during a wait, which exposes a design that raises stray events or resumes a retry the host no longer wants.

// File: rtl/brk_retry_pkg.sv
package brk_retry_pkg;
   typedef enum logic [1:0] {
      CH_OFF   = 2'd0,
      CH_ON    = 2'd1,
      CH_WAIT  = 2'd2,
      CH_LATCH = 2'd3
   } brk_state_e;

   localparam int unsigned CODE_W = 3;
endpackage

// File: rtl/brk_tick_gen.sv
module brk_tick_gen #(
   parameter int unsigned TICK_DIV = 1000
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick_o
);
   localparam int unsigned PW  = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
   localparam logic [PW-1:0] LIM = PW'(TICK_DIV - 1);

   logic [PW-1:0] div_q;

   assign tick_o = (div_q == LIM);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      div_q <= '0;
      else if (tick_o) div_q <= '0;
      else             div_q <= div_q + 1'b1;
   end
endmodule

// File: rtl/brk_cfg_regs.sv
module brk_cfg_regs #(
   parameter int unsigned NUM_CH = 2
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              we_i,
   input  logic [NUM_CH-1:0]                 auto_i,
   input  logic [brk_retry_pkg::CODE_W-1:0]  code_i,
   output logic [NUM_CH-1:0]                 auto_o,
   output logic [brk_retry_pkg::CODE_W-1:0]  code_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         auto_o <= '1;
         code_o <= '0;
      end else if (we_i) begin
         auto_o <= auto_i;
         code_o <= code_i;
      end
   end
endmodule

// File: rtl/brk_chan_fsm.sv
module brk_chan_fsm
   import brk_retry_pkg::*;
#(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_i,
   input  logic             en_req_i,
   input  logic             trip_i,
   input  logic             clr_i,
   input  logic             auto_i,
   input  logic [CNT_W-1:0] load_i,
   output logic             out_en_o,
   output logic             evt_o,
   output logic             latched_o
);
   brk_state_e st_q, st_d;
   logic [CNT_W-1:0] cnt_q;
   logic             evt_set;
   logic             start_wait;

   // a trip counts as a fault while driving, and re-arms a latched channel
   assign evt_set    = trip_i && (st_q == CH_ON || st_q == CH_LATCH);
   assign start_wait = (st_q == CH_ON) && en_req_i && trip_i && auto_i;

   always_comb begin
      st_d = st_q;
      if (!en_req_i) begin
         st_d = CH_OFF;
      end else begin
         unique case (st_q)
            CH_OFF:   st_d = CH_ON;
            CH_ON:    if (trip_i) st_d = auto_i ? CH_WAIT : CH_LATCH;
            CH_WAIT:  if (tick_i && cnt_q <= CNT_W'(1)) st_d = CH_ON;
            CH_LATCH: if (clr_i && !trip_i) st_d = CH_ON;
            default:  st_d = CH_OFF;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= CH_OFF;
         cnt_q <= '0;
         evt_o <= 1'b0;
      end else begin
         st_q <= st_d;
         if (start_wait)                      cnt_q <= load_i;
         else if (st_q == CH_WAIT && tick_i)  cnt_q <= cnt_q - 1'b1;
         if (evt_set)     evt_o <= 1'b1;
         else if (clr_i)  evt_o <= 1'b0;
      end
   end

   assign out_en_o  = (st_q == CH_ON);
   assign latched_o = (st_q == CH_LATCH);
endmodule

// File: rtl/brk_retry_ctrl.sv
module brk_retry_ctrl
   import brk_retry_pkg::*;
#(
   parameter int unsigned NUM_CH     = 2,
   parameter int unsigned TICK_DIV   = 1000,
   parameter int unsigned BASE_TICKS = 120
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] en_req_i,
   input  logic [NUM_CH-1:0] trip_i,
   input  logic [NUM_CH-1:0] evt_clr_i,
   input  logic              cfg_we_i,
   input  logic [NUM_CH-1:0] cfg_auto_i,
   input  logic [2:0]        cfg_code_i,
   output logic [NUM_CH-1:0] out_en_o,
   output logic [NUM_CH-1:0] evt_o
);
   localparam int unsigned MAX_SHIFT = (1 << CODE_W) - 1;
   localparam int unsigned CNT_W     = $clog2(BASE_TICKS + 1) + MAX_SHIFT;

   if (NUM_CH < 1)     begin : g_bad_ch   $error("NUM_CH must be at least 1");   end
   if (TICK_DIV < 1)   begin : g_bad_div  $error("TICK_DIV must be at least 1"); end
   if (BASE_TICKS < 1) begin : g_bad_base $error("BASE_TICKS must be at least 1"); end
   if (CNT_W > 40)     begin : g_bad_cnt  $error("cooling counter too wide");     end

   logic                tick;
   logic [NUM_CH-1:0]   mode_auto;
   logic [CODE_W-1:0]   code;
   logic [CNT_W-1:0]    load_val;
   logic [NUM_CH-1:0]   ch_latched;

   assign load_val = CNT_W'(BASE_TICKS) << code;

   brk_tick_gen #(.TICK_DIV(TICK_DIV)) tick_i_u (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick_o (tick)
   );

   brk_cfg_regs #(.NUM_CH(NUM_CH)) cfg_u (
      .clk    (clk),
      .rst_n  (rst_n),
      .we_i   (cfg_we_i),
      .auto_i (cfg_auto_i),
      .code_i (cfg_code_i),
      .auto_o (mode_auto),
      .code_o (code)
   );

   for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
      brk_chan_fsm #(.CNT_W(CNT_W)) fsm_u (
         .clk       (clk),
         .rst_n     (rst_n),
         .tick_i    (tick),
         .en_req_i  (en_req_i[g]),
         .trip_i    (trip_i[g]),
         .clr_i     (evt_clr_i[g]),
         .auto_i    (mode_auto[g]),
         .load_i    (load_val),
         .out_en_o  (out_en_o[g]),
         .evt_o     (evt_o[g]),
         .latched_o (ch_latched[g])
      );
   end
endmodule

// File: rtl/brk_retry_chk.sv
module brk_retry_chk #(
   parameter int unsigned NUM_CH = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic [NUM_CH-1:0] en_req_i,
   input logic [NUM_CH-1:0] trip_i,
   input logic [NUM_CH-1:0] evt_clr_i,
   input logic [NUM_CH-1:0] out_en_o,
   input logic [NUM_CH-1:0] evt_o,
   input logic [NUM_CH-1:0] ch_latched
);
   for (genvar i = 0; i < NUM_CH; i++) begin : g_a
      p_drop_en_r2: assert property (@(posedge clk) disable iff (!rst_n)
         !en_req_i[i] |=> !out_en_o[i]) else $error("R2 drop");
      p_rise_needs_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(out_en_o[i]) |-> $past(en_req_i[i])) else $error("R2 rise");
      p_trip_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
         (out_en_o[i] && trip_i[i]) |=> (!out_en_o[i] && evt_o[i])) else $error("R3");
      p_latch_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
         (ch_latched[i] && !evt_clr_i[i]) |=> !out_en_o[i]) else $error("R6 hold");
      p_clr_evt_r6: assert property (@(posedge clk) disable iff (!rst_n)
         (evt_clr_i[i] && !trip_i[i]) |=> !evt_o[i]) else $error("R6 clr");
      p_evt_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
         (evt_o[i] && !evt_clr_i[i]) |=> evt_o[i]) else $error("R8");
      p_clr_trip_r9: assert property (@(posedge clk) disable iff (!rst_n)
         (evt_clr_i[i] && trip_i[i] && (out_en_o[i] || ch_latched[i])) |=> (evt_o[i] && !out_en_o[i]))
         else $error("R9");
   end
endmodule

bind brk_retry_ctrl brk_retry_chk #(.NUM_CH(NUM_CH)) chk_i (
   .clk        (clk),
   .rst_n      (rst_n),
   .en_req_i   (en_req_i),
   .trip_i     (trip_i),
   .evt_clr_i  (evt_clr_i),
   .out_en_o   (out_en_o),
   .evt_o      (evt_o),
   .ch_latched (ch_latched)
);

// File: tb/brk_retry_ctrl_tb_top.sv
module brk_retry_ctrl_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int NUM_CH     = 2;
   localparam int TDIV       = 2;
   localparam int BASE       = 3;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [NUM_CH-1:0] en_req = '0, trip = '0, clr = '0, cfg_auto = '0;
   logic              cfg_we = 1'b0;
   logic [2:0]        cfg_code = '0;
   logic [NUM_CH-1:0] out_en, evt;

   always #(CLK_PERIOD/2) clk = ~clk;

   brk_retry_ctrl #(.NUM_CH(NUM_CH), .TICK_DIV(TDIV), .BASE_TICKS(BASE)) dut_i (
      .clk(clk), .rst_n(rst_n), .en_req_i(en_req), .trip_i(trip), .evt_clr_i(clr),
      .cfg_we_i(cfg_we), .cfg_auto_i(cfg_auto), .cfg_code_i(cfg_code),
      .out_en_o(out_en), .evt_o(evt));

   typedef struct {
      string      req;
      bit         is_range;
      logic [1:0] out_exp;
      logic [1:0] evt_exp;
      int         val, lo, hi;
   } item_t;

   item_t q[$];
   int n_cmp = 0, n_bad = 0;

   // monitor: pops each expected item and compares it with the live outputs
   initial begin
      forever begin
         wait (q.size() > 0);
         begin
            item_t it;
            it = q.pop_front();
            n_cmp++;
            if (it.is_range) begin
               if (it.val < it.lo || it.val > it.hi) begin
                  n_bad++;
                  $display("FAIL %s: off-time %0d expected %0d..%0d", it.req, it.val, it.lo, it.hi);
               end
            end else if (out_en !== it.out_exp || evt !== it.evt_exp) begin
               n_bad++;
               $display("FAIL %s: out_en=%b evt=%b expected out_en=%b evt=%b",
                        it.req, out_en, evt, it.out_exp, it.evt_exp);
            end
         end
      end
   end

   task automatic step();
      @(negedge clk);
   endtask

   task automatic exp_io(string r, logic [1:0] o, logic [1:0] e);
      item_t it;
      it.req = r; it.is_range = 1'b0; it.out_exp = o; it.evt_exp = e;
      it.val = 0; it.lo = 0; it.hi = 0;
      q.push_back(it);
      wait (q.size() == 0);
   endtask

   task automatic pulse_trip(logic [1:0] m);
      trip = m; step(); trip = '0;
   endtask

   task automatic pulse_clr(logic [1:0] m);
      clr = m; step(); clr = '0;
   endtask

   task automatic write_cfg(logic [1:0] a, logic [2:0] c);
      cfg_we = 1'b1; cfg_auto = a; cfg_code = c; step(); cfg_we = 1'b0;
   endtask

   // count negedges with the output low, starting from already-seen ones
   task automatic measure(string r, int ch, int seen, int code);
      item_t it;
      int cnt = seen;
      int n = BASE << code;
      step();
      while (out_en[ch] == 1'b0 && cnt < 5000) begin
         cnt++;
         step();
      end
      it.req = r; it.is_range = 1'b1; it.out_exp = '0; it.evt_exp = '0;
      it.val = cnt; it.lo = (n - 1) * TDIV + 1; it.hi = n * TDIV;
      q.push_back(it);
      wait (q.size() == 0);
   endtask

   initial begin
      repeat (3) step();
      exp_io("R1 reset", 2'b00, 2'b00);
      rst_n = 1'b1;
      step();
      exp_io("R1 after release", 2'b00, 2'b00);

      // defaults: both channels auto-retry, code 0
      en_req = 2'b11; step();
      exp_io("R2 enable", 2'b11, 2'b00);
      pulse_trip(2'b01);
      exp_io("R3 trip ch0", 2'b10, 2'b01);
      measure("R4 R1 default auto code0", 0, 1, 0);
      exp_io("R8 event sticky after retry", 2'b11, 2'b01);

      // clear during wait, then trip again at the retry
      pulse_trip(2'b01);
      step();
      pulse_clr(2'b01);
      exp_io("R8 clear mid-wait", 2'b10, 2'b00);
      measure("R8 wait unchanged by clear", 0, 3, 0);
      pulse_trip(2'b01);
      exp_io("R10 retrip", 2'b10, 2'b01);
      measure("R10 full delay repeats", 0, 1, 0);
      pulse_clr(2'b01);
      exp_io("R8 clear", 2'b11, 2'b00);

      // delay code scaling
      write_cfg(2'b11, 3'd2);
      pulse_trip(2'b10);
      exp_io("R3 trip ch1", 2'b01, 2'b10);
      measure("R5 code2", 1, 1, 2);
      pulse_clr(2'b10);
      write_cfg(2'b11, 3'd7);
      pulse_trip(2'b01);
      measure("R5 code7", 0, 1, 7);
      pulse_clr(2'b01);
      exp_io("R5 back on", 2'b11, 2'b00);

      // ch0 latchoff, ch1 auto
      write_cfg(2'b10, 3'd0);
      pulse_trip(2'b11);
      exp_io("R6 R7 both trip", 2'b00, 2'b11);
      repeat (10) step();
      exp_io("R7 ch1 retried ch0 held", 2'b10, 2'b11);
      repeat (30) step();
      exp_io("R6 still latched", 2'b10, 2'b11);
      pulse_clr(2'b11);
      exp_io("R6 clear is retry", 2'b11, 2'b00);

      // trip together with clear
      pulse_trip(2'b01);
      exp_io("R6 latch", 2'b10, 2'b01);
      clr = 2'b01; trip = 2'b01; step(); clr = '0; trip = '0;
      exp_io("R9 latched clr+trip", 2'b10, 2'b01);
      pulse_clr(2'b01);
      exp_io("R6 manual retry", 2'b11, 2'b00);
      clr = 2'b01; trip = 2'b01; step(); clr = '0; trip = '0;
      exp_io("R9 running clr+trip", 2'b10, 2'b01);
      pulse_clr(2'b01);
      exp_io("R9 recover", 2'b11, 2'b00);

      // enable drop and ignored trips
      pulse_trip(2'b10);
      en_req = 2'b01; step();
      exp_io("R2 drop during wait", 2'b01, 2'b10);
      repeat (20) step();
      exp_io("R2 no resume", 2'b01, 2'b10);
      pulse_clr(2'b10);
      pulse_trip(2'b10);
      exp_io("R11 trip on idle ch1", 2'b01, 2'b00);
      en_req = 2'b00; step();
      exp_io("R2 all off", 2'b00, 2'b00);
      pulse_trip(2'b11);
      exp_io("R11 trip on idle both", 2'b00, 2'b00);
      en_req = 2'b11; step();
      exp_io("R2 re-enable", 2'b11, 2'b00);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_cmp++; n_bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule